// File: doc/BRIEF.md
# SMBus Register Slave

This block is an SMBus slave that lets a host read and write a bank of 8-bit control registers over the two-wire bus. The SCL and SDA pins are oversampled in the system clock domain. They pass through a synchronizer and an edge detector, and a protocol engine works on the clean edge events that result. The slave pulls SDA low through an open-drain enable. It does not stretch the clock, and it does not compute or check a packet error code.

One command byte after the address picks the kind of access. With its top bit set, the command is an indexed single-byte access, and its low seven bits name the register. With its top bit clear, the command starts a sequential block transfer that always begins at register 0. A block write sends a byte count and then the data. A block read goes through a repeated start, and the slave then returns a fixed byte count followed by the registers in ascending order. Every register write also appears on a one-cycle strobe with its address and data, so nearby logic can react to it. A separate combinational port lets on-chip logic read any register at any time.

Top module: `smb_reg_slave`

## Requirements
- R1: After synchronous reset, every register reads 0x00, SDA is released (`sda_oe` = 0) and no write strobe is issued.
- R2: The slave acknowledges an address byte whose upper seven bits equal 0x69 (0xD2 for a write, 0xD3 for a read). For any other address it does not acknowledge, and it keeps SDA released for every later bit until the next start condition.
- R3: A command byte with bit 7 = 1 selects a single-byte access, and bits 6:0 give the register offset. The next data byte is written to that offset, and `reg_wr_en` pulses for one cycle with that offset and byte.
- R4: A single-byte read (address+W, command with bit 7 = 1, repeated start, address+R) returns the addressed register MSB first.
- R5: A command byte of 0x00 starts a block write. The slave acknowledges the byte count and every data byte, and it writes the data bytes to registers 0, 1, 2 and onward in the order received.
- R6: A block read (address+W, command 0x00, repeated start, address+R) returns a byte count equal to the number of registers (0x10 by default), followed by the registers from index 0 upward, each MSB first.
- R7: A master NACK after a transmitted byte ends transmission, and SDA stays released until the next start. A stop after any complete byte ends a transfer: the bytes already written are kept and later registers are left unchanged.
- R8: A data byte aimed at an offset at or above the register count is acknowledged but discarded, with no write strobe. A read from such an offset returns 0x00.
- R9: The slave begins pulling SDA low only while SCL is low.
- R10: `rd_data` always shows the current contents of the register selected by `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | 4 | Register index of the write |
| reg_wr_data | output | 8 | Byte written |
| rd_addr | input | 4 | Register index for the side read port |
| rd_data | output | 8 | Contents of register `rd_addr` |

## Verification
The hardest cases to reach are the transfers that the master cuts short. One is a block read that the master NACKs after two bytes and then keeps clocking. Another is a block write that announces eight bytes but stops after two. The bench drives both through its own bit-level master. It then clocks a further byte after the NACK and expects to read all ones, which shows the slave has released the bus. It also reads the whole bank through the side port to confirm that only the delivered bytes landed. Mismatched addresses and out-of-range offsets are handled the same way: each transfer is followed by extra bytes or a read-back, so that a wrong drive or a stray strobe becomes visible at the pins.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W    = 8;
    localparam int BITCNT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_WDATA,
        PH_TX,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic [6:0] ptr;
        logic       count_due;
    } xfer_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

    function automatic logic in_bank(input logic [6:0] p, input int n);
        return int'(p) < n;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[s] <= '1;
            else if (s == 0)
                stg[s] <= din;
            else
                stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= level;
    end

    assign level = stg[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int          NUM_REGS  = 16,
    parameter logic [7:0]  RESET_VAL = 8'h00,
    localparam int         AW        = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    logic [7:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= RESET_VAL;
            else if (wr_en && int'(wr_addr) == g)
                mem[g] <= wr_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

    // R3: a strobed byte is stored at the strobed index
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter int          NUM_REGS    = 16,
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  RESET_VAL   = 8'h00,
    localparam int         AW          = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    output logic          reg_wr_en,
    output logic [AW-1:0] reg_wr_addr,
    output logic [7:0]    reg_wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

    logic [1:0] lvl, rs, fl;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    smb_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({scl_in, sda_in}),
        .level (lvl),
        .rise  (rs),
        .fall  (fl)
    );

    assign scl_s    = lvl[1];
    assign sda_s    = lvl[0];
    assign scl_rise = rs[1];
    assign scl_fall = fl[1];
    assign start_ev = fl[0] & scl_s;
    assign stop_ev  = rs[0] & scl_s;

    phase_t               phase, next_ph;
    xfer_t                ctx;
    logic [BITCNT_W-1:0]  bit_cnt;
    logic                 in_ack, mack;
    logic [7:0]           shreg, tx_sh, tx_rd, tx_byte;

    smb_reg_bank #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .ra_addr (ctx.ptr[AW-1:0]),
        .ra_data (tx_rd),
        .rb_addr (rd_addr),
        .rb_data (rd_data)
    );

    always_comb begin
        if (ctx.count_due)                 tx_byte = COUNT_BYTE;
        else if (in_bank(ctx.ptr, NUM_REGS)) tx_byte = tx_rd;
        else                               tx_byte = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            next_ph     <= PH_IDLE;
            ctx         <= '0;
            bit_cnt     <= '0;
            in_ack      <= 1'b0;
            mack        <= 1'b1;
            sda_oe      <= 1'b0;
            shreg       <= '0;
            tx_sh       <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (start_ev) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_CMD, PH_COUNT, PH_WDATA: begin
                        if (scl_rise && !in_ack) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && !in_ack && bit_cnt == 4'd8) begin
                            in_ack <= 1'b1;
                            case (phase)
                                PH_ADDR: begin
                                    if (addr_hit(shreg, DEV_ADDR)) begin
                                        sda_oe  <= 1'b1;
                                        next_ph <= shreg[0] ? PH_TX : PH_CMD;
                                    end else begin
                                        phase <= PH_IGNORE;
                                    end
                                end
                                PH_CMD: begin
                                    sda_oe        <= 1'b1;
                                    ctx.ptr       <= shreg[7] ? shreg[6:0] : 7'd0;
                                    ctx.count_due <= ~shreg[7];
                                    next_ph       <= shreg[7] ? PH_WDATA : PH_COUNT;
                                end
                                PH_COUNT: begin
                                    sda_oe  <= 1'b1;
                                    next_ph <= PH_WDATA;
                                end
                                default: begin
                                    sda_oe  <= 1'b1;
                                    next_ph <= PH_WDATA;
                                    ctx.ptr <= ctx.ptr + 1'b1;
                                    if (in_bank(ctx.ptr, NUM_REGS)) begin
                                        reg_wr_en   <= 1'b1;
                                        reg_wr_addr <= ctx.ptr[AW-1:0];
                                        reg_wr_data <= shreg;
                                    end
                                end
                            endcase
                        end else if (scl_fall && in_ack) begin
                            in_ack  <= 1'b0;
                            bit_cnt <= '0;
                            phase   <= next_ph;
                            if (next_ph == PH_TX) begin
                                tx_sh  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                if (ctx.count_due) ctx.count_due <= 1'b0;
                                else               ctx.ptr <= ctx.ptr + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_rise && in_ack) begin
                            mack <= sda_s;
                        end else if (scl_fall && !in_ack) begin
                            if (bit_cnt == 4'd7) begin
                                in_ack  <= 1'b1;
                                sda_oe  <= 1'b0;
                                bit_cnt <= 4'd8;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                sda_oe  <= ~tx_sh[6];
                            end
                        end else if (scl_fall && in_ack) begin
                            in_ack  <= 1'b0;
                            bit_cnt <= '0;
                            if (!mack) begin
                                tx_sh  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                if (ctx.count_due) ctx.count_due <= 1'b0;
                                else               ctx.ptr <= ctx.ptr + 1'b1;
                            end else begin
                                phase  <= PH_IGNORE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: reset leaves the bus released and no strobe pending
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_oe && !reg_wr_en));

    // R9: the slave starts pulling SDA only while synchronized SCL is low
    a_r9_drive_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R2/R7: a slave that is ignoring the bus never drives it
    a_r2_ignore_released: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE) |-> !sda_oe);

    // R3: each data byte yields a single-cycle strobe
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R8: strobes only come from received data bytes, never while transmitting
    a_r8_no_strobe_in_tx: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TX) |-> !reg_wr_en);

endmodule

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 16;
    localparam int AW         = 4;

    typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wr_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_line;
    logic          sda_oe, reg_wr_en;
    logic [AW-1:0] reg_wr_addr, rd_addr;
    logic [7:0]    reg_wr_data, rd_data;

    int   total = 0, bad = 0, r9_viol = 0;
    bit   prev_oe = 1'b0;
    logic [7:0] mdl [NREG];
    wr_t  exp_q [$];

    assign sda_line = sda_m & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    smb_reg_slave i_smb_reg_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .sda_oe      (sda_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: write strobes against the scoreboard queue; SDA drive timing
    always @(negedge clk) begin : mon
        wr_t e;
        if (!rst && reg_wr_en) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R8 unexpected write strobe", {reg_wr_addr, reg_wr_data}, 0);
            else begin
                e = exp_q.pop_front();
                chk(reg_wr_addr == e.a && reg_wr_data == e.d, "R3/R5 write strobe",
                    {reg_wr_addr, reg_wr_data}, {e.a, e.d});
            end
        end
        if (!prev_oe && sda_oe && scl_m) r9_viol++;
        prev_oe = sda_oe;
    end

    task automatic expect_wr(input int a, input logic [7:0] d);
        exp_q.push_back('{a: AW'(a), d: d});
        mdl[a] = d;
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic m_wr(input logic [7:0] b, output logic nak);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half();
            scl_m = 1'b1; half(); half();
            scl_m = 1'b0; half();
        end
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        nak = sda_line; half();
        scl_m = 1'b0; half();
    endtask

    task automatic m_rd(input bit last, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            half();
            scl_m = 1'b1; half();
            b[i] = sda_line; half();
            scl_m = 1'b0;
        end
        half();
        sda_m = last; half();
        scl_m = 1'b1; half(); half();
        scl_m = 1'b0; half();
        sda_m = 1'b1;
    endtask

    task automatic wr_ack(input logic [7:0] b, input string tag);
        logic nak;
        m_wr(b, nak);
        chk(nak == 1'b0, tag, nak, 0);
    endtask

    task automatic bank_matches(input string tag);
        int mism = 0;
        for (int i = 0; i < NREG; i++) begin
            rd_addr = AW'(i);
            @(negedge clk);
            if (rd_data !== mdl[i]) mism++;
        end
        chk(mism == 0, tag, mism, 0);
    endtask

    task automatic byte_read(input logic [7:0] cmd, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        m_start();
        wr_ack(8'hD2, "R2 address write ack");
        wr_ack(cmd, "R4 command ack");
        m_start();
        wr_ack(8'hD3, "R2 address read ack");
        m_rd(1'b1, v);
        m_stop();
        chk(v == exp, tag, v, exp);
    endtask

    initial begin
        logic nak;
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        rd_addr = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
        bank_matches("R1/R10 registers at default");

        // R3: indexed byte writes, including the last register
        m_start();
        wr_ack(8'hD2, "R2 address ack");
        wr_ack(8'h85, "R3 command ack");
        expect_wr(5, 8'hA5);
        wr_ack(8'hA5, "R3 data ack");
        m_stop();
        m_start();
        wr_ack(8'hD2, "R2 address ack");
        wr_ack(8'h8F, "R3 command ack top offset");
        expect_wr(15, 8'h5C);
        wr_ack(8'h5C, "R3 data ack top offset");
        m_stop();

        // R2: foreign address is not acked and bus stays released
        m_start();
        m_wr(8'hA0, nak);
        chk(nak == 1'b1, "R2 foreign address nack", nak, 1);
        m_wr(8'h81, nak);
        chk(nak == 1'b1, "R2 released after mismatch", nak, 1);
        m_stop();

        // R4: byte reads
        byte_read(8'h85, 8'hA5, "R4 byte read offset 5");
        byte_read(8'h8F, 8'h5C, "R4 byte read offset 15");

        // R5: block write of four bytes from register 0
        m_start();
        wr_ack(8'hD2, "R2 address ack");
        wr_ack(8'h00, "R5 block command ack");
        wr_ack(8'h04, "R5 count ack");
        expect_wr(0, 8'h11); wr_ack(8'h11, "R5 data0 ack");
        expect_wr(1, 8'h22); wr_ack(8'h22, "R5 data1 ack");
        expect_wr(2, 8'h33); wr_ack(8'h33, "R5 data2 ack");
        expect_wr(3, 8'h44); wr_ack(8'h44, "R5 data3 ack");
        m_stop();
        bank_matches("R5/R10 bank after block write");

        // R6: full block read
        m_start();
        wr_ack(8'hD2, "R2 address ack");
        wr_ack(8'h00, "R6 block command ack");
        m_start();
        wr_ack(8'hD3, "R2 read address ack");
        m_rd(1'b0, v);
        chk(v == 8'(NREG), "R6 byte count", v, NREG);
        for (int i = 0; i < NREG; i++) begin
            m_rd(i == NREG-1, v);
            chk(v == mdl[i], $sformatf("R6 block byte %0d", i), v, mdl[i]);
        end
        m_stop();

        // R7: master NACK after two data bytes, then keeps clocking
        m_start();
        wr_ack(8'hD2, "R2 address ack");
        wr_ack(8'h00, "R7 block command ack");
        m_start();
        wr_ack(8'hD3, "R2 read address ack");
        m_rd(1'b0, v);
        chk(v == 8'(NREG), "R7 byte count", v, NREG);
        m_rd(1'b0, v);
        chk(v == 8'h11, "R7 first byte", v, 8'h11);
        m_rd(1'b1, v);
        chk(v == 8'h22, "R7 nacked byte", v, 8'h22);
        m_rd(1'b1, v);
        chk(v == 8'hFF, "R7 bus released after nack", v, 8'hFF);
        m_stop();

        // R7: block write announcing eight bytes, stopped after two
        m_start();
        wr_ack(8'hD2, "R2 address ack");
        wr_ack(8'h00, "R7 block command ack");
        wr_ack(8'h08, "R7 count ack");
        expect_wr(0, 8'h77); wr_ack(8'h77, "R7 data0 ack");
        expect_wr(1, 8'h88); wr_ack(8'h88, "R7 data1 ack");
        m_stop();
        bank_matches("R7/R10 only delivered bytes written");

        // R8: out-of-range offset
        m_start();
        wr_ack(8'hD2, "R2 address ack");
        wr_ack(8'hA0, "R8 command ack");
        wr_ack(8'h99, "R8 data still acked");
        m_stop();
        bank_matches("R8 bank unchanged");
        byte_read(8'hA0, 8'h00, "R8 out-of-range read");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3/R5 all expected writes seen", exp_q.size(), 0);
        chk(r9_viol == 0, "R9 drive starts with SCL low", r9_viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule